// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one channel of a 16-bit timer. A single counter advances on a chosen count tick. The tick comes from the system clock, from the system clock divided by 2, 4 or 8, or from rising edges of an external clock pin. Four general registers watch that counter. Each one is set up on its own either as an output compare, which changes its output pin when the counter reaches the stored value, or as an input capture, which stores the counter value when a chosen edge arrives on its input pin.

Software reaches the channel through a small word-wide register port with a combinational read path. Through that port it can:
- pick a register whose event clears the counter;
- pair registers so that a capture keeps its previous value or a compare reloads itself from its partner;
- preset the output levels;
- enable interrupt sources.

A level on the output-disable trigger forces every output pin back to its preset level. The pins stay there until software acknowledges the event.

Top module: `ccu_timer_channel`

Register addresses: 0 control, 1 mode, 2 initial levels, 3 status, 4 interrupt enable, 5 counter, 8 to 11 general registers 0 to 3. Any other address reads as zero.

## Requirements
- R1: While run (control bit 3) is 1, the 16-bit counter (address 5) adds one on every count tick. It wraps from 0xFFFF to 0x0000, and that wrap sets the sticky overflow flag (status bit 4). A counter cleared in the same cycle does not set the flag.
- R2: Control bits [2:0] select the tick.
  - Values 0, 1, 2 and 3 give a tick once every 1, 2, 4 or 8 clocks. The tick is taken from a free-running 3-bit divider.
  - Value 4 gives a tick on each rising edge of ext_clk, after that pin passes a two-flop synchronizer.
  - Values 5 to 7 give no tick.
- R3: The mode register (address 1) holds one 4-bit field per general register i, at bits [4i+3:4i].
  - Field bit 2 set selects capture; clear selects compare.
  - A compare register matches on a tick when the counter equals its value.
- R4: In compare mode, field bits [1:0] act on tio_out[i] in the cycle after a match: 0 leaves it unchanged, 1 drives 0, 2 drives 1, 3 toggles it.
- R5: In capture mode with run set, field bit 0 captures on rising edges and bit 1 on falling edges of tio_in[i], both sampled through a two-flop synchronizer. A capture copies the counter into the register. General registers reset to 0xFFFF.
- R6: Writing the initial-level register (address 2, bits [3:0]) stores the levels and also loads them onto the outputs at once.
- R7: Control bits [6:4] = k, with k from 1 to 4, clear the counter to 0 on a match or capture of register k-1. A value of 0 clears nothing.
- R8: Status bits [3:0] are sticky match/capture flags. Writing 1 to a status bit clears it, and a new event in the same cycle wins. irq is the OR of status bits [4:0] ANDed with enable bits [4:0] at address 4.
- R9: Control bit 7 pairs registers 0 and 2, and control bit 8 pairs registers 1 and 3.
  - In a pair, a capture on the lower register moves its old value into the upper register.
  - In a pair, a compare match on the lower register reloads it from the upper register.
- R10: A high level on out_dis_trig, after a two-flop synchronizer, sets status bit 5. While that bit is set, tio_out shows the initial levels. Writing 1 to status bit 5 clears it only when the synchronized trigger is low.
- R11: A bus write to the counter or to a general register takes priority over any hardware update of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| ext_clk | input | 1 | External count clock |
| tio_in | input | 4 | Capture inputs, one per general register |
| out_dis_trig | input | 1 | Output-disable trigger, active high |
| tio_out | output | 4 | Compare outputs, one per general register |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with its default parameters: a 16-bit counter and four registers forming two buffer pairs. With these values a counter preset near 0xFFFF reaches the wrap and the overflow flag within a few dozen cycles. They also let every clear-select code, both buffer pairs and all four compare actions act within the same run. With the 3-bit divider, every divide ratio shows several ticks inside a short window of cycles.

// File: rtl/ccu_pkg.sv
`timescale 1ns/1ps
package ccu_pkg;
  localparam int PRE_W = 3;

  typedef enum logic [2:0] {
    CS_DIV1 = 3'd0, CS_DIV2 = 3'd1, CS_DIV4 = 3'd2, CS_DIV8 = 3'd3, CS_EXT = 3'd4
  } clk_src_e;

  localparam int A_CTRL = 0;
  localparam int A_MODE = 1;
  localparam int A_INIT = 2;
  localparam int A_STAT = 3;
  localparam int A_IEN  = 4;
  localparam int A_CNT  = 5;
  localparam int A_GR0  = 8;

  // Output level after a compare match for a 2-bit action code
  function automatic logic apply_act(input logic cur, input logic [1:0] act);
    case (act)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  // Divider hit: the low sel bits of the free-running divider are all ones
  function automatic logic prescale_hit(input logic [PRE_W-1:0] pre, input logic [2:0] sel);
    logic [PRE_W-1:0] mask;
    mask = (PRE_W'(1) << sel) - PRE_W'(1);
    return (pre & mask) == mask;
  endfunction
endpackage

// File: rtl/ccu_edge_det.sv
`timescale 1ns/1ps
module ccu_edge_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/ccu_tick_gen.sv
`timescale 1ns/1ps
module ccu_tick_gen
  import ccu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  input  logic       ext_rise,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic             div_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_W'(1);
  end

  assign div_hit = prescale_hit(pre_q, sel);

  always_comb begin
    tick = 1'b0;
    if (run) begin
      if (sel == CS_EXT)       tick = ext_rise;
      else if (sel <= CS_DIV8) tick = div_hit;
    end
  end

  // R2
  div2_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel == CS_DIV2) |=> (!tick || sel != CS_DIV2));
endmodule

// File: rtl/ccu_timer_channel.sv
`timescale 1ns/1ps
module ccu_timer_channel
  import ccu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NREG  = 4,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic             bus_we,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             ext_clk,
  input  logic [NREG-1:0]  tio_in,
  input  logic             out_dis_trig,
  output logic [NREG-1:0]  tio_out,
  output logic             irq
);
  localparam int NPAIR  = NREG / 2;
  localparam int CTRL_W = 7 + NPAIR;
  localparam int MODE_W = 4 * NREG;
  localparam int STAT_W = NREG + 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [MODE_W-1:0] mode_q;
  logic [NREG-1:0]   init_q, out_q, flag_q;
  logic [NREG:0]     ien_q;
  logic              ovf_q, dis_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  gr_q [NREG];

  logic              run, tick, ext_rise, clr_ev, ovf_ev;
  logic              cnt_wr, init_wr, stat_wr, trig_lvl;
  logic [2:0]        clk_sel, clr_sel;
  logic [NPAIR-1:0]  buf_en;
  logic [NREG-1:0]   in_rise, in_fall, is_cap, match_ev, cap_ev, gr_wr, shift_in, reload;
  logic [1:0]        act [NREG];
  logic [CNT_W-1:0]  shift_val [NREG];
  logic [CNT_W-1:0]  reload_val [NREG];
  logic [CNT_W-1:0]  clr_mask;
  logic              unused_lvl_ext, unused_ext_fall, unused_trig_rise, unused_trig_fall;
  logic [NREG-1:0]   unused_in_lvl;

  assign run     = ctrl_q[3];
  assign clk_sel = ctrl_q[2:0];
  assign clr_sel = ctrl_q[6:4];
  assign buf_en  = ctrl_q[7 +: NPAIR];
  assign cnt_wr  = bus_we && (bus_addr == AW'(A_CNT));
  assign init_wr = bus_we && (bus_addr == AW'(A_INIT));
  assign stat_wr = bus_we && (bus_addr == AW'(A_STAT));
  assign clr_mask = stat_wr ? bus_wdata : '0;

  ccu_edge_det #(.W(1)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk),
    .lvl(unused_lvl_ext), .rise(ext_rise), .fall(unused_ext_fall));

  ccu_edge_det #(.W(NREG)) u_in_sync (
    .clk(clk), .rst_n(rst_n), .din(tio_in),
    .lvl(unused_in_lvl), .rise(in_rise), .fall(in_fall));

  ccu_edge_det #(.W(1)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .din(out_dis_trig),
    .lvl(trig_lvl), .rise(unused_trig_rise), .fall(unused_trig_fall));

  ccu_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(clk_sel),
    .ext_rise(ext_rise), .tick(tick));

  // Per-register event detection and register update
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [AW-1:0] GR_ADDR = AW'(A_GR0 + i);
    assign is_cap[i]   = mode_q[4*i+2];
    assign act[i]      = mode_q[4*i +: 2];
    assign match_ev[i] = tick && !is_cap[i] && (cnt_q == gr_q[i]);
    assign cap_ev[i]   = run && is_cap[i] &&
                         ((act[i][0] && in_rise[i]) || (act[i][1] && in_fall[i]));
    assign gr_wr[i]    = bus_we && (bus_addr == GR_ADDR);

    if (i >= NPAIR) begin : g_upper
      assign shift_in[i]   = buf_en[i-NPAIR] && cap_ev[i-NPAIR];
      assign shift_val[i]  = gr_q[i-NPAIR];
      assign reload[i]     = 1'b0;
      assign reload_val[i] = '0;
    end else begin : g_lower
      assign shift_in[i]   = 1'b0;
      assign shift_val[i]  = '0;
      assign reload[i]     = buf_en[i] && match_ev[i];
      assign reload_val[i] = gr_q[i+NPAIR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           gr_q[i] <= '1;
      else if (gr_wr[i])    gr_q[i] <= bus_wdata;
      else if (shift_in[i]) gr_q[i] <= shift_val[i];
      else if (cap_ev[i])   gr_q[i] <= cnt_q;
      else if (reload[i])   gr_q[i] <= reload_val[i];
    end

    // R5
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ev[i] && !gr_wr[i] && !shift_in[i]) |=> gr_q[i] == $past(cnt_q));
  end

  always_comb begin
    clr_ev = 1'b0;
    for (int k = 0; k < NREG; k++)
      if ((int'(clr_sel) == k + 1) && (match_ev[k] || cap_ev[k])) clr_ev = 1'b1;
  end

  assign ovf_ev = tick && (cnt_q == '1) && !clr_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_wr) cnt_q <= bus_wdata;
    else if (clr_ev) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      init_q <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      flag_q <= '0;
      ovf_q  <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      if (bus_we && bus_addr == AW'(A_CTRL)) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (bus_we && bus_addr == AW'(A_MODE)) mode_q <= bus_wdata[MODE_W-1:0];
      if (bus_we && bus_addr == AW'(A_IEN))  ien_q  <= bus_wdata[NREG:0];
      if (init_wr) begin
        init_q <= bus_wdata[NREG-1:0];
        out_q  <= bus_wdata[NREG-1:0];
      end else begin
        for (int k = 0; k < NREG; k++)
          if (match_ev[k]) out_q[k] <= apply_act(out_q[k], act[k]);
      end
      flag_q <= (flag_q & ~clr_mask[NREG-1:0]) | match_ev | cap_ev;
      ovf_q  <= (ovf_q & ~clr_mask[NREG]) | ovf_ev;
      dis_q  <= (dis_q & ~clr_mask[NREG+1]) | trig_lvl;
    end
  end

  assign tio_out = dis_q ? init_q : out_q;
  assign irq     = |({ovf_q, flag_q} & ien_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_CTRL)) bus_rdata = CNT_W'(ctrl_q);
    if (bus_addr == AW'(A_MODE)) bus_rdata = CNT_W'(mode_q);
    if (bus_addr == AW'(A_INIT)) bus_rdata = CNT_W'(init_q);
    if (bus_addr == AW'(A_STAT)) bus_rdata = CNT_W'({dis_q, ovf_q, flag_q});
    if (bus_addr == AW'(A_IEN))  bus_rdata = CNT_W'(ien_q);
    if (bus_addr == AW'(A_CNT))  bus_rdata = cnt_q;
    for (int k = 0; k < NREG; k++)
      if (bus_addr == AW'(A_GR0 + k)) bus_rdata = gr_q[k];
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_ev && !cnt_wr) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R1
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> ovf_q);
  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !cnt_wr) |=> cnt_q == '0);
  // R10
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && $past(dis_q) && !$past(init_wr)) |-> $stable(tio_out));
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q != '0 || ovf_q));
endmodule

// File: tb/ccu_timer_channel_tb.sv
`timescale 1ns/1ps
module ccu_timer_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] rdata;
  logic        ext = 1'b0;
  logic [3:0]  tin = '0;
  logic        trig = 1'b0;
  logic [3:0]  tout;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ccu_timer_channel u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_rdata(rdata), .ext_clk(ext), .tio_in(tin), .out_dis_trig(trig),
    .tio_out(tout), .irq(irq));

  // Behavioural reference model
  int m_cnt, m_ctrl, m_mode, m_init, m_out, m_flag, m_ovf, m_dis, m_ien, m_pre;
  int m_gr[4];
  bit m_e1, m_e2, m_e3, m_g1, m_g2;
  bit [3:0] m_t1, m_t2, m_t3;

  function automatic int m_read(input int a);
    if (a == 0) return m_ctrl;
    if (a == 1) return m_mode;
    if (a == 2) return m_init;
    if (a == 3) return (m_dis << 5) | (m_ovf << 4) | m_flag;
    if (a == 4) return m_ien;
    if (a == 5) return m_cnt;
    if (a >= 8 && a <= 11) return m_gr[a-8];
    return 0;
  endfunction

  function automatic void m_reset();
    m_cnt = 0; m_ctrl = 0; m_mode = 0; m_init = 0; m_out = 0; m_flag = 0;
    m_ovf = 0; m_dis = 0; m_ien = 0; m_pre = 0;
    foreach (m_gr[i]) m_gr[i] = 16'hFFFF;
    m_e1 = 0; m_e2 = 0; m_e3 = 0; m_g1 = 0; m_g2 = 0;
    m_t1 = 0; m_t2 = 0; m_t3 = 0;
  endfunction

  function automatic void m_step();
    int sel = m_ctrl & 7;
    bit run = m_ctrl[3];
    bit tick;
    bit [3:0] rs = m_t2 & ~m_t3;
    bit [3:0] fs = ~m_t2 & m_t3;
    bit [3:0] mt, cp;
    int cs, ncnt, nout, wa;
    int ngr[4];
    bit clr, ov;
    if (sel < 4) tick = run && ((m_pre % (1 << sel)) == (1 << sel) - 1);
    else         tick = run && sel == 4 && m_e2 && !m_e3;
    for (int i = 0; i < 4; i++) begin
      int md = (m_mode >> (4*i)) & 15;
      mt[i] = tick && !md[2] && m_cnt == m_gr[i];
      cp[i] = run && md[2] && ((md[0] && rs[i]) || (md[1] && fs[i]));
    end
    cs = (m_ctrl >> 4) & 7;
    clr = cs >= 1 && cs <= 4 && (mt[cs-1] || cp[cs-1]);
    ov = tick && m_cnt == 16'hFFFF && !clr;
    wa = we ? int'(addr) : -1;
    ncnt = (wa == 5) ? int'(wdata) : clr ? 0 : tick ? (m_cnt + 1) & 16'hFFFF : m_cnt;
    for (int i = 0; i < 4; i++) begin
      ngr[i] = m_gr[i];
      if (wa == 8 + i) ngr[i] = wdata;
      else if (i >= 2 && m_ctrl[7 + i - 2] && cp[i-2]) ngr[i] = m_gr[i-2];
      else if (cp[i]) ngr[i] = m_cnt;
      else if (i < 2 && m_ctrl[7 + i] && mt[i]) ngr[i] = m_gr[i+2];
    end
    nout = m_out;
    if (wa == 2) nout = wdata & 15;
    else for (int i = 0; i < 4; i++) if (mt[i]) begin
      int a = (m_mode >> (4*i)) & 3;
      if (a == 1) nout = nout & ~(1 << i);
      else if (a == 2) nout = nout | (1 << i);
      else if (a == 3) nout = nout ^ (1 << i);
    end
    if (wa == 3) begin
      m_flag = m_flag & ~(wdata & 15);
      if (wdata[4]) m_ovf = 0;
      if (wdata[5]) m_dis = 0;
    end
    m_flag = m_flag | mt | cp;
    if (ov) m_ovf = 1;
    if (m_g2) m_dis = 1;
    if (wa == 0) m_ctrl = wdata & 16'h1FF;
    if (wa == 1) m_mode = wdata;
    if (wa == 2) m_init = wdata & 15;
    if (wa == 4) m_ien = wdata & 16'h1F;
    m_cnt = ncnt;
    m_out = nout;
    foreach (m_gr[i]) m_gr[i] = ngr[i];
    m_pre = (m_pre + 1) % 8;
    m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext;
    m_t3 = m_t2; m_t2 = m_t1; m_t1 = tin;
    m_g2 = m_g1; m_g1 = trig;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  function automatic string tag_of(input int a);
    if (a == 0) return "R2 control";
    if (a == 1) return "R3 mode";
    if (a == 2) return "R6 initial levels";
    if (a == 3 || a == 4) return "R8 status/enable";
    if (a == 5) return "R1 counter";
    if (a >= 8 && a <= 11) return "R5 general register";
    return "R11 unmapped";
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every clock, 2 ns after the active edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      cmp("R4/R10 tio_out", int'(tout), m_dis ? m_init : m_out);
      cmp("R8 irq", int'(irq), (((m_ovf << 4) | m_flag) & m_ien) != 0);
      cmp(tag_of(int'(addr)), int'(rdata), m_read(int'(addr)));
    end
  end

  int scan_idx = 0;
  int scan[12] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 5, 3};

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      we = 1'b0;
      addr = 4'(scan[scan_idx]);
      scan_idx = (scan_idx + 1) % 12;
    end
  endtask

  task automatic snap(input string tag, input int a);
    @(negedge clk);
    we = 1'b0; addr = 4'(a);
    @(posedge clk);
    #2;
    cmp(tag, int'(rdata), m_read(a));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    snap("R1 reset counter", 5);
    snap("R8 reset status", 3);
    snap("R5 reset general register", 8);

    // R1: free counting, wrap and overflow
    wr(0, 16'h0008);
    idle(20);
    snap("R1 counting", 5);
    wr(5, 16'hFFF0);
    wr(4, 16'h0010);
    idle(30);
    snap("R1 wrap overflow", 3);
    wr(3, 16'h0010);
    idle(3);
    snap("R8 write-one clear", 3);

    // R2: divided and external ticks
    wr(0, 16'h0009); idle(25); snap("R2 div2", 5);
    wr(0, 16'h000A); idle(25); snap("R2 div4", 5);
    wr(0, 16'h000B); idle(40); snap("R2 div8", 5);
    wr(0, 16'h000C);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); ext = ~ext;
      idle(3);
    end
    snap("R2 external", 5);
    wr(0, 16'h000D); idle(10); snap("R2 no source", 5);

    // R3 R4 R6 R7: compares with clear on register 0
    wr(0, 0); wr(5, 0);
    wr(2, 16'h0004);
    snap("R6 init loaded", 2);
    wr(1, 16'h0123);
    snap("R3 mode", 1);
    wr(8, 40); wr(9, 15); wr(10, 25);
    wr(4, 16'h000F);
    wr(0, 16'h0018);
    idle(150);
    snap("R7 clear on match", 5);
    snap("R4 flags after matches", 3);
    wr(3, 16'h000F);
    snap("R8 clear flags", 3);

    // R5: captures on both edges and on rising edges
    wr(0, 0);
    wr(1, 16'h7050);
    wr(0, 16'h0008);
    for (int k = 0; k < 6; k++) begin
      idle(7 + k);
      @(negedge clk); tin[3] = ~tin[3]; tin[1] = ~tin[1];
    end
    idle(5);
    snap("R5 capture rise", 9);
    snap("R5 capture both", 11);

    // R9: buffer pairs, capture shift and compare reload
    wr(0, 0); wr(5, 0); tin = '0;
    wr(1, 16'h0035);
    wr(9, 10); wr(11, 30);
    wr(0, 16'h01A8);
    for (int k = 0; k < 5; k++) begin
      idle(9 + 2*k);
      @(negedge clk); tin[0] = 1'b1;
      idle(4);
      @(negedge clk); tin[0] = 1'b0;
    end
    idle(60);
    snap("R9 capture lower", 8);
    snap("R9 capture shifted", 10);
    snap("R9 compare reload", 9);

    // R10: output disable
    wr(2, 16'h000A);
    @(negedge clk); trig = 1'b1;
    idle(6);
    snap("R10 disable status", 3);
    wr(3, 16'h0020);
    snap("R10 clear ignored while high", 3);
    @(negedge clk); trig = 1'b0;
    idle(4);
    wr(3, 16'h0020);
    idle(3);
    snap("R10 disable cleared", 3);

    // R11: bus write beats counting
    wr(0, 16'h0008);
    wr(5, 16'h1234);
    snap("R11 counter write", 5);
    idle(10);
    snap("R11 unmapped read", 6);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule